// File: doc/BRIEF.md
# Partitioned Context-Tagged Translation Buffer

A small fully associative translation buffer that maps 8 KiB virtual pages to a stored translation word. Every entry carries a page tag together with a partition number, a real/virtual flag and a context number, plus lock and used bits. A lookup is purely combinational: it compares the presented page against all entries and returns hit, the winning index, a multi-match flag and the stored word. Real translations ignore the context; virtual translations require it to match.

A single command port performs one maintenance operation per clock: insert (at a given slot or at a slot the block picks), invalidate everything, and three demap flavours scoped by partition, by context or by page, plus clearing all used bits. A separate diagnostic index returns any entry's tag word and translation word in the same cycle. Replacement uses the lock and used bits: invalid slots first, then unlocked slots not recently used, and when none is left all used bits are cleared before choosing.

Top module: `xlat_buf`

## Requirements
- R1: A real lookup (`lk_real`=1, `lk_valid`=1) hits an entry that is valid, has its real flag set, and matches `lk_pid` and the page number; the stored context is ignored.
- R2: A virtual lookup (`lk_real`=0) hits only an entry that is valid, has its real flag clear, and matches `lk_pid`, `lk_ctx` and the page number.
- R3: Address bits [12:0] of `lk_va` and `op_va` never affect a match; only bits above bit 12 form the page number.
- R4: With several matching entries, `lk_idx` and `lk_data` come from the lowest index and `lk_multi` is 1; with exactly one match `lk_multi` is 0.
- R5: Command 1 (insert) with `op_idx` below the entry count writes that slot (valid=1, lock=`op_lock`, used=0) even if it is locked; `op_idx` values from the entry count up to all ones minus one write nothing.
- R6: Insert with `op_idx` all ones picks the lowest invalid slot; else the lowest valid slot that is unlocked and unused; else clears every used bit and picks the lowest unlocked slot; with all slots valid and locked nothing is written.
- R7: A lookup hit sets the used bit of the winning entry at the next clock edge; command 6 clears all used bits, and a hit in the same cycle still sets its own bit.
- R8: Command 2 clears the valid bit of every entry, locked ones included.
- R9: Command 3 invalidates valid entries whose partition equals `op_pid` and whose lock bit is clear; locked entries stay.
- R10: Command 4 invalidates every entry matching both `op_pid` and `op_ctx`, locked or not.
- R11: Command 5 invalidates entries matching `op_pid`, `op_real` and the page number, and also `op_ctx` when `op_real` is 0.
- R12: `dg_tag` returns {valid, lock, used, real, partition, context, page number} from MSB to LSB for entry `dg_idx`, and `dg_data` its translation word, in the same cycle.
- R13: After reset every entry reads back with an all-zero tag word and data word, and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Command: 0 none, 1 insert, 2 invalidate all, 3 demap partition, 4 demap context, 5 demap page, 6 clear used |
| op_idx | input | IDX_W+1 | Insert slot; all ones picks automatically |
| op_va | input | VA_W | Command virtual address |
| op_pid | input | PID_W | Command partition |
| op_real | input | 1 | Command real flag |
| op_ctx | input | CTX_W | Command context |
| op_lock | input | 1 | Lock bit for insert |
| op_data | input | DATA_W | Translation word for insert |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_pid | input | PID_W | Lookup partition |
| lk_real | input | 1 | Lookup real flag |
| lk_ctx | input | CTX_W | Lookup context |
| lk_hit | output | 1 | Lookup matched |
| lk_idx | output | IDX_W | Winning entry |
| lk_data | output | DATA_W | Winning translation word |
| lk_multi | output | 1 | More than one entry matched |
| dg_idx | input | IDX_W | Diagnostic entry select |
| dg_tag | output | TAG_W | Diagnostic tag word |
| dg_data | output | DATA_W | Diagnostic translation word |

## Verification
Lookup outputs and the diagnostic words depend only on the current inputs and stored state, so they are due in the same cycle the inputs are applied, while every command and every used-bit update becomes visible only after the next rising edge. The bench drives all inputs at the falling edge, compares outputs one nanosecond later against a model that reflects the state after the previous rising edge, and advances that model at the rising edge using the inputs that were held across it. Directed sequences pin down hard expected hits and indices for each corner case before a long seeded random run.

// File: rtl/xlat_buf_pkg.sv
package xlat_buf_pkg;
  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_INSERT     = 3'd1,
    OP_INV_ALL    = 3'd2,
    OP_DEMAP_PART = 3'd3,
    OP_DEMAP_CTX  = 3'd4,
    OP_DEMAP_PAGE = 3'd5,
    OP_CLR_USED   = 3'd6
  } xb_op_e;
endpackage

// File: rtl/xlat_buf_match.sv
// Per-entry comparators for lookup and for the three demap scopes.
module xlat_buf_match #(
  parameter int PID_W = 3,
  parameter int CTX_W = 8,
  parameter int VPN_W = 19
) (
  input  logic             e_valid,
  input  logic             e_lock,
  input  logic             e_real,
  input  logic [PID_W-1:0] e_pid,
  input  logic [CTX_W-1:0] e_ctx,
  input  logic [VPN_W-1:0] e_vpn,
  input  logic             lk_real,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             op_real,
  input  logic [PID_W-1:0] op_pid,
  input  logic [CTX_W-1:0] op_ctx,
  input  logic [VPN_W-1:0] op_vpn,
  output logic             lk_match,
  output logic             dm_part,
  output logic             dm_ctx,
  output logic             dm_page
);
  logic op_pid_eq, op_ctx_eq;

  always_comb begin
    lk_match  = e_valid && (e_pid == lk_pid) && (e_real == lk_real) &&
                (e_vpn == lk_vpn) && (lk_real || (e_ctx == lk_ctx));
    op_pid_eq = e_valid && (e_pid == op_pid);
    op_ctx_eq = (e_ctx == op_ctx);
    dm_part   = op_pid_eq && !e_lock;
    dm_ctx    = op_pid_eq && op_ctx_eq;
    dm_page   = op_pid_eq && (e_real == op_real) && (e_vpn == op_vpn) &&
                (op_real || op_ctx_eq);
  end
endmodule

// File: rtl/xlat_buf_pick.sv
// Lowest-index selector with a more-than-one flag.
module xlat_buf_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic          multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    found = |req;
    multi = |(req & (req - N'(1)));
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_buf_pkg::*;
#(
  parameter int  ENTRIES   = 8,
  parameter int  VA_W      = 32,
  parameter int  PAGE_BITS = 13,
  parameter int  PID_W     = 3,
  parameter int  CTX_W     = 8,
  parameter int  DATA_W    = 32,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OPIDX_W   = IDX_W + 1,
  localparam int VPN_W     = VA_W - PAGE_BITS,
  localparam int TAG_W     = 4 + PID_W + CTX_W + VPN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_code,
  input  logic [OPIDX_W-1:0] op_idx,
  input  logic [VA_W-1:0]    op_va,
  input  logic [PID_W-1:0]   op_pid,
  input  logic               op_real,
  input  logic [CTX_W-1:0]   op_ctx,
  input  logic               op_lock,
  input  logic [DATA_W-1:0]  op_data,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [PID_W-1:0]   lk_pid,
  input  logic               lk_real,
  input  logic [CTX_W-1:0]   lk_ctx,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [DATA_W-1:0]  lk_data,
  output logic               lk_multi,
  input  logic [IDX_W-1:0]   dg_idx,
  output logic [TAG_W-1:0]   dg_tag,
  output logic [DATA_W-1:0]  dg_data
);
  // Entry state
  logic [ENTRIES-1:0] v_q, l_q, u_q, r_q, v_d, l_d, u_d, r_d;
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [PID_W-1:0]   pid_d [ENTRIES];
  logic [CTX_W-1:0]   ctx_q [ENTRIES];
  logic [CTX_W-1:0]   ctx_d [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_d [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [DATA_W-1:0]  dat_d [ENTRIES];

  xb_op_e             op;
  logic [VPN_W-1:0]   lk_vpn, op_vpn;
  logic [ENTRIES-1:0] lk_req, dm_part, dm_ctx, dm_page;
  logic               any_match, match_multi;
  logic               inv_found, free_found, unl_found;
  logic [IDX_W-1:0]   inv_idx, free_idx, unl_idx, vic_idx, ins_tgt;
  logic               inv_m, free_m, unl_m;
  logic               ins_auto, ins_expl, ins_do, clr_used, upd_en;

  assign op     = xb_op_e'(op_code);
  assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];
  assign op_vpn = op_va[VA_W-1:PAGE_BITS];

  // Comparators, one per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_buf_match #(.PID_W(PID_W), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_match (
      .e_valid (v_q[g]),     .e_lock (l_q[g]),     .e_real (r_q[g]),
      .e_pid   (pid_q[g]),   .e_ctx  (ctx_q[g]),   .e_vpn  (vpn_q[g]),
      .lk_real (lk_real),    .lk_pid (lk_pid),     .lk_ctx (lk_ctx),
      .lk_vpn  (lk_vpn),     .op_real(op_real),    .op_pid (op_pid),
      .op_ctx  (op_ctx),     .op_vpn (op_vpn),     .lk_match(lk_req[g]),
      .dm_part (dm_part[g]), .dm_ctx (dm_ctx[g]),  .dm_page(dm_page[g])
    );
  end

  xlat_buf_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick_hit (
    .req(lk_req), .found(any_match), .idx(lk_idx), .multi(match_multi));
  xlat_buf_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick_inv (
    .req(~v_q), .found(inv_found), .idx(inv_idx), .multi(inv_m));
  xlat_buf_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick_free (
    .req(v_q & ~l_q & ~u_q), .found(free_found), .idx(free_idx), .multi(free_m));
  xlat_buf_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick_unl (
    .req(~l_q), .found(unl_found), .idx(unl_idx), .multi(unl_m));

  // Lookup and diagnostic outputs
  always_comb begin
    lk_hit   = lk_valid && any_match;
    lk_multi = lk_hit && match_multi;
    lk_data  = dat_q[lk_idx];
    dg_tag   = '0;
    dg_data  = '0;
    if (32'(dg_idx) < ENTRIES) begin
      dg_tag  = {v_q[dg_idx], l_q[dg_idx], u_q[dg_idx], r_q[dg_idx],
                 pid_q[dg_idx], ctx_q[dg_idx], vpn_q[dg_idx]};
      dg_data = dat_q[dg_idx];
    end
  end

  // Slot choice
  always_comb begin
    ins_auto = (op_idx == '1);
    ins_expl = !ins_auto && (32'(op_idx) < ENTRIES);
    vic_idx  = inv_found ? inv_idx : (free_found ? free_idx : unl_idx);
    ins_do   = (op == OP_INSERT) &&
               (ins_expl || (ins_auto && (inv_found || free_found || unl_found)));
    ins_tgt  = ins_expl ? op_idx[IDX_W-1:0] : vic_idx;
    clr_used = (op == OP_CLR_USED) ||
               ((op == OP_INSERT) && ins_auto && !inv_found && !free_found && unl_found);
    upd_en   = (op != OP_NONE) || lk_hit;
  end

  // Next state
  always_comb begin
    v_d = v_q; l_d = l_q; u_d = u_q; r_d = r_q;
    pid_d = pid_q; ctx_d = ctx_q; vpn_d = vpn_q; dat_d = dat_q;
    if (clr_used) u_d = '0;
    if (lk_hit) u_d[lk_idx] = 1'b1;
    unique case (op)
      OP_INSERT: if (ins_do) begin
        v_d[ins_tgt]   = 1'b1;
        l_d[ins_tgt]   = op_lock;
        u_d[ins_tgt]   = 1'b0;
        r_d[ins_tgt]   = op_real;
        pid_d[ins_tgt] = op_pid;
        ctx_d[ins_tgt] = op_ctx;
        vpn_d[ins_tgt] = op_vpn;
        dat_d[ins_tgt] = op_data;
      end
      OP_INV_ALL:    v_d = '0;
      OP_DEMAP_PART: v_d = v_q & ~dm_part;
      OP_DEMAP_CTX:  v_d = v_q & ~dm_ctx;
      OP_DEMAP_PAGE: v_d = v_q & ~dm_page;
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0; l_q <= '0; u_q <= '0; r_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pid_q[i] <= '0; ctx_q[i] <= '0; vpn_q[i] <= '0; dat_q[i] <= '0;
      end
    end else if (upd_en) begin
      v_q <= v_d; l_q <= l_d; u_q <= u_d; r_q <= r_d;
      pid_q <= pid_d; ctx_q <= ctx_d; vpn_q <= vpn_d; dat_q <= dat_d;
    end
  end

  // Checks next to the logic
  p_hit_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> v_q[lk_idx] && lk_req[lk_idx]);
  p_hit_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_req & ((ENTRIES'(1) << lk_idx) - ENTRIES'(1))) == '0));
  p_multi_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit && ($countones(lk_req) > 1));
  p_used_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && (op_code != 3'd1)) |=> u_q[$past(lk_idx)]);
  p_inv_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd2) |=> (v_q == '0));
  p_part_keep_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd3) |=> ((v_q & $past(v_q & l_q)) == $past(v_q & l_q)));
  p_ins_expl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_code == 3'd1) && (32'(op_idx) < ENTRIES)) |=> v_q[$past(op_idx[IDX_W-1:0])]);
endmodule

// File: tb/xlat_buf_tb.sv
`timescale 1ns/1ps
module xlat_buf_tb;
  localparam int N = 8, IW = 3, VA_W = 32, PB = 13, PID_W = 3, CTX_W = 8, DW = 32;
  localparam int VPN_W = VA_W - PB, TAG_W = 4 + PID_W + CTX_W + VPN_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] op_code; logic [IW:0] op_idx; logic [VA_W-1:0] op_va;
  logic [PID_W-1:0] op_pid; logic op_real; logic [CTX_W-1:0] op_ctx;
  logic op_lock; logic [DW-1:0] op_data;
  logic lk_valid; logic [VA_W-1:0] lk_va; logic [PID_W-1:0] lk_pid;
  logic lk_real; logic [CTX_W-1:0] lk_ctx;
  logic lk_hit, lk_multi; logic [IW-1:0] lk_idx; logic [DW-1:0] lk_data;
  logic [IW-1:0] dg_idx; logic [TAG_W-1:0] dg_tag; logic [DW-1:0] dg_data;

  xlat_buf u_dut (.*);

  int errors = 0, checks = 0;
  // staged stimulus
  logic [2:0] s_op; logic [IW:0] s_idx; logic [VPN_W-1:0] s_vpn; logic [PID_W-1:0] s_pid;
  logic s_real, s_lock; logic [CTX_W-1:0] s_ctx; logic [DW-1:0] s_data;
  logic s_lv, s_lreal; logic [VPN_W-1:0] s_lvpn; logic [PID_W-1:0] s_lpid;
  logic [CTX_W-1:0] s_lctx; logic [IW-1:0] s_dg;
  // hard expectation for the next step
  bit x_on; bit x_hit; int x_idx; string x_tag;
  // model
  bit m_v[N], m_l[N], m_u[N], m_r[N];
  logic [PID_W-1:0] m_p[N]; logic [CTX_W-1:0] m_c[N];
  logic [VPN_W-1:0] m_vpn[N]; logic [DW-1:0] m_d[N];
  bit mh; int mi; int mcnt;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_match(int i);
    return m_v[i] && m_p[i] == s_lpid && m_r[i] == s_lreal && m_vpn[i] == s_lvpn &&
           (s_lreal || m_c[i] == s_lctx);
  endfunction

  task automatic step();
    logic [TAG_W-1:0] et;
    @(negedge clk);
    op_code = s_op; op_idx = s_idx; op_va = {s_vpn, 13'($urandom)};
    op_pid = s_pid; op_real = s_real; op_ctx = s_ctx; op_lock = s_lock; op_data = s_data;
    lk_valid = s_lv; lk_va = {s_lvpn, 13'($urandom)}; // R3: random offset bits
    lk_pid = s_lpid; lk_real = s_lreal; lk_ctx = s_lctx; dg_idx = s_dg;
    #1;
    mh = 0; mi = 0; mcnt = 0;
    for (int i = N - 1; i >= 0; i--) if (m_match(i)) begin mcnt++; mi = i; end
    mh = s_lv && mcnt > 0;
    chk(s_lreal ? "R1 hit" : "R2 hit", 64'(lk_hit), 64'(mh));
    if (mh) begin
      chk("R4 idx", 64'(lk_idx), 64'(mi));
      chk("R4 data", 64'(lk_data), 64'(m_d[mi]));
      chk("R4 multi", 64'(lk_multi), 64'(mcnt > 1));
    end
    et = {m_v[s_dg], m_l[s_dg], m_u[s_dg], m_r[s_dg], m_p[s_dg], m_c[s_dg], m_vpn[s_dg]};
    chk("R12 tag", 64'(dg_tag), 64'(et));
    chk("R12 data", 64'(dg_data), 64'(m_d[s_dg]));
    if (x_on) begin
      chk({x_tag, " hit"}, 64'(lk_hit), 64'(x_hit));
      if (x_hit) chk({x_tag, " idx"}, 64'(lk_idx), 64'(x_idx));
      x_on = 0;
    end
    @(posedge clk);
    model_step();
  endtask

  task automatic model_step();
    int inv, fre, unl, t;
    bit clr, auto_i;
    inv = -1; fre = -1; unl = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!m_v[i]) inv = i;
      if (m_v[i] && !m_l[i] && !m_u[i]) fre = i;
      if (!m_l[i]) unl = i;
    end
    auto_i = (s_idx == '1);
    clr = (s_op == 3'd6) || (s_op == 3'd1 && auto_i && inv < 0 && fre < 0 && unl >= 0);
    if (clr) for (int i = 0; i < N; i++) m_u[i] = 0;
    if (mh) m_u[mi] = 1;
    case (s_op)
      3'd1: begin
        t = auto_i ? (inv >= 0 ? inv : (fre >= 0 ? fre : unl)) : (int'(s_idx) < N ? int'(s_idx) : -1);
        if (t >= 0) begin
          m_v[t] = 1; m_l[t] = s_lock; m_u[t] = 0; m_r[t] = s_real;
          m_p[t] = s_pid; m_c[t] = s_ctx; m_vpn[t] = s_vpn; m_d[t] = s_data;
        end
      end
      3'd2: for (int i = 0; i < N; i++) m_v[i] = 0;
      3'd3: for (int i = 0; i < N; i++) if (m_p[i] == s_pid && !m_l[i]) m_v[i] = 0;
      3'd4: for (int i = 0; i < N; i++) if (m_p[i] == s_pid && m_c[i] == s_ctx) m_v[i] = 0;
      3'd5: for (int i = 0; i < N; i++)
              if (m_p[i] == s_pid && m_r[i] == s_real && m_vpn[i] == s_vpn &&
                  (s_real || m_c[i] == s_ctx)) m_v[i] = 0;
      default: ;
    endcase
  endtask

  task automatic cmd(logic [2:0] o, logic [IW:0] idx, logic [VPN_W-1:0] vpn, logic [PID_W-1:0] pid,
                     logic rl, logic [CTX_W-1:0] cx, logic lk, logic [DW-1:0] d);
    s_op = o; s_idx = idx; s_vpn = vpn; s_pid = pid; s_real = rl; s_ctx = cx; s_lock = lk; s_data = d;
  endtask
  task automatic look(logic [VPN_W-1:0] vpn, logic [PID_W-1:0] pid, logic rl, logic [CTX_W-1:0] cx);
    s_lv = 1; s_lvpn = vpn; s_lpid = pid; s_lreal = rl; s_lctx = cx;
  endtask
  task automatic idle(); cmd(0, 0, 0, 0, 0, 0, 0, 0); s_lv = 0; endtask
  task automatic expect_lk(string tag, bit h, int i); x_on = 1; x_hit = h; x_idx = i; x_tag = tag; endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_l[i] = 0; m_u[i] = 0; m_r[i] = 0; m_p[i] = 0; m_c[i] = 0; m_vpn[i] = 0; m_d[i] = 0;
    end
    x_on = 0; idle(); s_dg = 0;
    op_code = 0; op_idx = 0; op_va = 0; op_pid = 0; op_real = 0; op_ctx = 0; op_lock = 0; op_data = 0;
    lk_valid = 0; lk_va = 0; lk_pid = 0; lk_real = 0; lk_ctx = 0; dg_idx = 0;
    // R13: reset state, all entries read zero
    for (int i = 0; i < N; i++) begin
      @(negedge clk); dg_idx = IW'(i); lk_valid = 1; #1;
      chk("R13 tag", 64'(dg_tag), 0); chk("R13 data", 64'(dg_data), 0); chk("R13 hit", 64'(lk_hit), 0);
    end
    @(negedge clk); rst_n = 1; lk_valid = 0;

    // R2/R3 virtual entry at slot 0
    cmd(1, 0, 5, 1, 0, 3, 0, 32'hA0); step(); idle();
    look(5, 1, 0, 3); expect_lk("R2 ctx match", 1, 0); step();
    look(5, 1, 0, 4); expect_lk("R2 ctx differs", 0, 0); step();
    look(5, 2, 0, 3); expect_lk("R2 pid differs", 0, 0); step();
    // R1 real entry at slot 1, context ignored
    cmd(1, 1, 6, 1, 1, 7, 0, 32'hA1); step(); idle();
    look(6, 1, 1, 0); expect_lk("R1 ctx ignored", 1, 1); step();
    look(6, 1, 0, 7); expect_lk("R1 mode differs", 0, 0); step();
    // R4 duplicate at slot 2
    cmd(1, 2, 5, 1, 0, 3, 0, 32'hA2); step(); idle();
    look(5, 1, 0, 3); expect_lk("R4 lowest", 1, 0); step();
    // R5 out-of-range index writes nothing
    cmd(1, 9, 12, 1, 0, 0, 0, 32'hB9); step(); idle();
    look(12, 1, 0, 0); expect_lk("R5 ignored idx", 0, 0); step();
    // R9 locked entry at slot 3 survives partition demap
    cmd(1, 3, 7, 1, 0, 9, 1, 32'hA3); step();
    cmd(3, 0, 0, 1, 0, 0, 0, 0); step(); idle();
    look(7, 1, 0, 9); expect_lk("R9 locked kept", 1, 3); step();
    look(5, 1, 0, 3); expect_lk("R9 unlocked gone", 0, 0); step();
    // R5 explicit overwrite of locked slot
    cmd(1, 3, 8, 1, 0, 9, 0, 32'hA4); step(); idle();
    look(8, 1, 0, 9); expect_lk("R5 overwrite locked", 1, 3); step();
    // R8 invalidate all
    cmd(1, 4, 9, 0, 0, 1, 1, 32'hA5); step();
    cmd(2, 0, 0, 0, 0, 0, 0, 0); step(); idle();
    look(9, 0, 0, 1); expect_lk("R8 locked cleared", 0, 0); step();
    // R6 auto fill, even slots locked
    for (int k = 0; k < N; k++) begin cmd(1, '1, VPN_W'(20 + k), 0, 0, 0, (k % 2) == 0, DW'(k)); step(); end
    idle();
    look(23, 0, 0, 0); expect_lk("R6 auto order", 1, 3); step();
    cmd(1, '1, 40, 0, 0, 0, 0, 32'hC0); s_lv = 0; step(); idle();
    look(40, 0, 0, 0); expect_lk("R6 free unused", 1, 1); step();
    look(25, 0, 0, 0); step(); look(27, 0, 0, 0); step();
    // R7 used now set on 1,3,5,7: next auto clears all used and takes slot 1
    cmd(1, '1, 41, 0, 0, 0, 0, 32'hC1); s_lv = 0; step(); idle();
    look(41, 0, 0, 0); expect_lk("R6 used clear", 1, 1); s_dg = 5; step();
    cmd(6, 0, 0, 0, 0, 0, 0, 0); look(25, 0, 0, 0); s_dg = 5; step(); idle(); s_dg = 5; step(); // R7
    // R10 demap context
    cmd(1, 1, 50, 2, 1, 6, 1, 32'hD0); step();
    cmd(4, 0, 0, 2, 0, 6, 0, 0); step(); idle();
    look(50, 2, 1, 6); expect_lk("R10 ctx demap", 0, 0); step();
    // R11 demap page, context relevant for virtual only
    cmd(1, 2, 60, 2, 0, 1, 0, 32'hD1); step();
    cmd(5, 0, 60, 2, 0, 2, 0, 0); step(); idle();
    look(60, 2, 0, 1); expect_lk("R11 ctx mismatch kept", 1, 2); step();
    cmd(5, 0, 60, 2, 0, 1, 0, 0); step(); idle();
    look(60, 2, 0, 1); expect_lk("R11 page demap", 0, 0); step();
    // R6 all locked: auto insert drops
    for (int k = 0; k < N; k++) begin cmd(1, 4'(k), VPN_W'(70 + k), 3, 0, 0, 1, DW'(k)); step(); end
    cmd(1, '1, 99, 3, 0, 0, 0, 32'hEE); step(); idle();
    look(99, 3, 0, 0); expect_lk("R6 all locked", 0, 0); step();
    cmd(2, 0, 0, 0, 0, 0, 0, 0); step();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 16);
      cmd(0, 0, VPN_W'($urandom % 4), PID_W'($urandom % 2), 1'($urandom), CTX_W'($urandom % 2),
          ($urandom % 5) == 0, $urandom);
      if (r < 6) begin
        s_op = 1;
        case ($urandom % 10)
          0: s_idx = 4'(8 + $urandom % 7);
          1, 2, 3, 4: s_idx = '1;
          default: s_idx = 4'($urandom % N);
        endcase
      end else if (r == 6) s_op = (($urandom % 8) == 0) ? 3'd2 : 3'd0;
      else if (r >= 7 && r <= 10) s_op = 3'(r - 4);
      s_lv = ($urandom % 4) != 0;
      s_lvpn = VPN_W'($urandom % 4); s_lpid = PID_W'($urandom % 2);
      s_lreal = 1'($urandom); s_lctx = CTX_W'($urandom % 2);
      s_dg = IW'($urandom % N);
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule